// File: doc/BRIEF.md
# Periodic Polarity Bit Stuffer and Destuffer

This block forces line transitions into a serial payload stream. It holds two separate bit-serial paths. The transmit path counts accepted payload bits. After every group of N bits it emits one extra bit, which is the inverse of the last bit of that group. While that extra bit goes out, the upstream source is held off for one bit slot. The receive path counts N payload bits and then removes the next valid bit. If that removed bit does not differ from the bit before it, the receive path raises an error.

A 2-bit mode input selects the group length (4, 8 or 16 bits) or turns stuffing off. Each path has a start pulse that opens a new payload, so grouping begins with the first payload bit after the header. The header is sent around this block. CRC bits that follow the data are treated as payload and are grouped the same way. Both paths are combinational from input to output: a bit offered in a cycle appears at the output in that same cycle.

Top module: `bitstuff_top`

## Requirements
- R1: With mode code 0 the transmit path is transparent: `tx_out_valid`, `tx_out_bit` and `tx_in_ready` follow `tx_in_valid`, `tx_in_bit` and `tx_out_ready` in the same cycle, and no bit is inserted.
- R2: Mode codes 1, 2 and 3 select group lengths of 4, 8 and 16. After every group of that many accepted payload bits (`tx_in_valid && tx_in_ready`), exactly one extra output bit follows before the next payload bit.
- R3: The inserted bit is the complement of the last payload bit of its group.
- R4: While the inserted bit is offered, `tx_out_valid` is 1 and `tx_in_ready` is 0. `tx_in_ready` returns to follow `tx_out_ready` in the cycle after the inserted bit is accepted (`tx_out_valid && tx_out_ready`).
- R5: A `tx_start` pulse clears the group count and discards an inserted bit that has not yet been accepted. A payload bit offered in the same cycle counts as bit 1 of the new group.
- R6: With a nonzero mode, the receive path passes N valid payload bits (`rx_out_valid` high, `rx_out_bit` equal to `rx_in_bit`) and then drops the next valid input bit (`rx_out_valid` low). With mode 0 every valid bit passes.
- R7: `rx_stuff_err` is 1, in the cycle of a dropped bit, exactly when that dropped bit equals the last payload bit before it. It is 0 in all other cycles.
- R8: A `rx_start` pulse clears the receive group count and a pending drop. A bit valid in the same cycle counts as bit 1 of the new group.
- R9: With the transmit output looped into the receive input, the receive output reproduces the transmit payload exactly, for every mode and for any stall pattern on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 = off, 1/2/3 = group of 4/8/16 bits |
| tx_start | input | 1 | Opens a new transmit payload |
| tx_in_valid | input | 1 | Upstream payload bit valid |
| tx_in_bit | input | 1 | Upstream payload bit |
| tx_in_ready | output | 1 | Transmit path accepts a payload bit |
| tx_out_valid | output | 1 | Line bit valid |
| tx_out_bit | output | 1 | Line bit (payload or inserted) |
| tx_out_ready | input | 1 | Line slot available |
| rx_start | input | 1 | Opens a new receive payload |
| rx_in_valid | input | 1 | Received line bit valid |
| rx_in_bit | input | 1 | Received line bit |
| rx_out_valid | output | 1 | Recovered payload bit valid |
| rx_out_bit | output | 1 | Recovered payload bit |
| rx_stuff_err | output | 1 | Dropped bit failed the polarity rule |

## Verification
If a group counter is off by one, the first inserted bit shows up one payload bit early or late. Because each path is combinational, this shift is visible at the outputs within at most 17 accepted bits. A lost or stuck pending flag shows up as a missing or doubled extra bit. It can also show up as `tx_in_ready` staying low for longer than one accepted slot. In the loopback runs, either fault shifts every later recovered bit and pulses `rx_stuff_err`. A wrong polarity register shows up directly on the inserted bit, and again at the receiver as an error flag.

// File: rtl/stuff_pkg.sv
package stuff_pkg;

    typedef enum logic [1:0] {
        STF_OFF   = 2'd0,
        STF_SHORT = 2'd1,
        STF_MID   = 2'd2,
        STF_LONG  = 2'd3
    } stuff_mode_e;

    // Per-path hold state: an extra slot is armed, and the polarity reference.
    typedef struct packed {
        logic armed;
        logic ref_bit;
    } slot_state_t;

    function automatic int unsigned group_len(input stuff_mode_e m,
                                              input int unsigned len_a,
                                              input int unsigned len_b,
                                              input int unsigned len_c);
        case (m)
            STF_SHORT: return len_a;
            STF_MID:   return len_b;
            STF_LONG:  return len_c;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/stuff_group_ctr.sv
module stuff_group_ctr
    import stuff_pkg::*;
#(
    parameter int unsigned GRP_A = 4,
    parameter int unsigned GRP_B = 8,
    parameter int unsigned GRP_C = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  stuff_mode_e mode,
    input  logic        clear,
    input  logic        step,
    output logic        at_last
);
    localparam int unsigned CNT_W = $clog2(GRP_C + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_eff;
    int unsigned      len;

    always_comb begin
        len     = group_len(mode, GRP_A, GRP_B, GRP_C);
        cnt_eff = clear ? '0 : cnt_q;
        at_last = (mode != STF_OFF) && ((32'(cnt_eff) + 32'd1) >= len);
    end

    always_ff @(posedge clk) begin
        if (rst || mode == STF_OFF) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= at_last ? '0 : cnt_eff + 1'b1;
        end else begin
            cnt_q <= cnt_eff;
        end
    end
endmodule

// File: rtl/bitstuff_tx.sv
module bitstuff_tx
    import stuff_pkg::*;
#(
    parameter int unsigned GRP_A = 4,
    parameter int unsigned GRP_B = 8,
    parameter int unsigned GRP_C = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  stuff_mode_e mode,
    input  logic        start,
    input  logic        in_valid,
    input  logic        in_bit,
    output logic        in_ready,
    output logic        out_valid,
    output logic        out_bit,
    input  logic        out_ready
);
    slot_state_t st_q, st_d;
    logic        armed_eff;
    logic        take;
    logic        at_last;

    stuff_group_ctr #(.GRP_A(GRP_A), .GRP_B(GRP_B), .GRP_C(GRP_C)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .clear   (start),
        .step    (take),
        .at_last (at_last)
    );

    always_comb begin
        armed_eff = st_q.armed && !start && (mode != STF_OFF);
        out_valid = armed_eff || in_valid;
        out_bit   = armed_eff ? ~st_q.ref_bit : in_bit;
        in_ready  = !armed_eff && out_ready;
        take      = in_valid && in_ready;

        st_d       = st_q;
        st_d.armed = armed_eff;
        if (armed_eff && out_ready) begin
            st_d.armed = 1'b0;
        end else if (take && at_last) begin
            st_d.armed   = 1'b1;
            st_d.ref_bit = in_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/bitstuff_rx.sv
module bitstuff_rx
    import stuff_pkg::*;
#(
    parameter int unsigned GRP_A = 4,
    parameter int unsigned GRP_B = 8,
    parameter int unsigned GRP_C = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  stuff_mode_e mode,
    input  logic        start,
    input  logic        in_valid,
    input  logic        in_bit,
    output logic        out_valid,
    output logic        out_bit,
    output logic        stuff_err
);
    slot_state_t st_q, st_d;
    logic        drop_eff;
    logic        at_last;

    stuff_group_ctr #(.GRP_A(GRP_A), .GRP_B(GRP_B), .GRP_C(GRP_C)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .clear   (start),
        .step    (out_valid),
        .at_last (at_last)
    );

    always_comb begin
        drop_eff  = st_q.armed && !start && (mode != STF_OFF);
        out_valid = in_valid && !drop_eff;
        out_bit   = in_bit;
        stuff_err = in_valid && drop_eff && (in_bit == st_q.ref_bit);

        st_d       = st_q;
        st_d.armed = drop_eff;
        if (in_valid && drop_eff) begin
            st_d.armed = 1'b0;
        end else if (out_valid) begin
            st_d.ref_bit = in_bit;
            st_d.armed   = at_last;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/bitstuff_top.sv
module bitstuff_top
    import stuff_pkg::*;
#(
    parameter int unsigned GRP_A = 4,
    parameter int unsigned GRP_B = 8,
    parameter int unsigned GRP_C = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       tx_start,
    input  logic       tx_in_valid,
    input  logic       tx_in_bit,
    output logic       tx_in_ready,
    output logic       tx_out_valid,
    output logic       tx_out_bit,
    input  logic       tx_out_ready,
    input  logic       rx_start,
    input  logic       rx_in_valid,
    input  logic       rx_in_bit,
    output logic       rx_out_valid,
    output logic       rx_out_bit,
    output logic       rx_stuff_err
);
    stuff_mode_e mode_e;
    assign mode_e = stuff_mode_e'(mode);

    bitstuff_tx #(.GRP_A(GRP_A), .GRP_B(GRP_B), .GRP_C(GRP_C)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_e),
        .start     (tx_start),
        .in_valid  (tx_in_valid),
        .in_bit    (tx_in_bit),
        .in_ready  (tx_in_ready),
        .out_valid (tx_out_valid),
        .out_bit   (tx_out_bit),
        .out_ready (tx_out_ready)
    );

    bitstuff_rx #(.GRP_A(GRP_A), .GRP_B(GRP_B), .GRP_C(GRP_C)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_e),
        .start     (rx_start),
        .in_valid  (rx_in_valid),
        .in_bit    (rx_in_bit),
        .out_valid (rx_out_valid),
        .out_bit   (rx_out_bit),
        .stuff_err (rx_stuff_err)
    );
endmodule

// File: rtl/bitstuff_chk.sv
module bitstuff_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       tx_start,
    input logic       tx_in_valid,
    input logic       tx_in_bit,
    input logic       tx_in_ready,
    input logic       tx_out_valid,
    input logic       tx_out_bit,
    input logic       tx_out_ready,
    input logic       rx_in_valid,
    input logic       rx_out_valid,
    input logic       rx_stuff_err
);
    logic last_out;
    logic have_last;
    logic extra_slot;

    // The line slot is open but upstream is held: an inserted bit is going out.
    assign extra_slot = tx_out_valid && tx_out_ready && !tx_in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_out  <= 1'b0;
            have_last <= 1'b0;
        end else if (tx_out_valid && tx_out_ready) begin
            last_out  <= tx_out_bit;
            have_last <= 1'b1;
        end
    end

    assert_bypass_R1: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0) |-> (tx_in_ready == tx_out_ready && tx_out_valid == tx_in_valid
                            && tx_out_bit == tx_in_bit));

    assert_flip_R3: assert property (@(posedge clk) disable iff (rst)
        (extra_slot && have_last) |-> (tx_out_bit != last_out));

    assert_one_slot_R4: assert property (@(posedge clk) disable iff (rst)
        extra_slot |=> (tx_in_ready == tx_out_ready));

    assert_rx_bypass_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0) |-> (rx_out_valid == rx_in_valid && !rx_stuff_err));

    assert_err_on_drop_R7: assert property (@(posedge clk) disable iff (rst)
        rx_stuff_err |-> (rx_in_valid && !rx_out_valid));

    assert_start_ready_R5: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> (tx_in_ready == tx_out_ready));
endmodule

bind bitstuff_top bitstuff_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode         (mode),
    .tx_start     (tx_start),
    .tx_in_valid  (tx_in_valid),
    .tx_in_bit    (tx_in_bit),
    .tx_in_ready  (tx_in_ready),
    .tx_out_valid (tx_out_valid),
    .tx_out_bit   (tx_out_bit),
    .tx_out_ready (tx_out_ready),
    .rx_in_valid  (rx_in_valid),
    .rx_out_valid (rx_out_valid),
    .rx_stuff_err (rx_stuff_err)
);

// File: tb/bitstuff_top_test.sv
module bitstuff_top_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'd0;
    logic       tx_start = 1'b0, tx_in_valid = 1'b0, tx_in_bit = 1'b0, tx_out_ready = 1'b0;
    logic       rx_start = 1'b0, d_rx_valid = 1'b0, d_rx_bit = 1'b0, loop = 1'b0;
    logic       tx_in_ready, tx_out_valid, tx_out_bit;
    logic       rx_in_valid, rx_in_bit, rx_out_valid, rx_out_bit, rx_stuff_err;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    bit payload [0:255];
    bit exp_bit [0:511];
    bit exp_stf [0:511];
    int exp_len;

    always #2.5 clk = ~clk;

    assign rx_in_valid = loop ? (tx_out_valid && tx_out_ready) : d_rx_valid;
    assign rx_in_bit   = loop ? tx_out_bit : d_rx_bit;

    bitstuff_top uut (
        .clk(clk), .rst(rst), .mode(mode),
        .tx_start(tx_start), .tx_in_valid(tx_in_valid), .tx_in_bit(tx_in_bit),
        .tx_in_ready(tx_in_ready), .tx_out_valid(tx_out_valid), .tx_out_bit(tx_out_bit),
        .tx_out_ready(tx_out_ready), .rx_start(rx_start), .rx_in_valid(rx_in_valid),
        .rx_in_bit(rx_in_bit), .rx_out_valid(rx_out_valid), .rx_out_bit(rx_out_bit),
        .rx_stuff_err(rx_stuff_err)
    );

    function automatic int glen(input logic [1:0] m);
        case (m)
            2'd1:    return 4;
            2'd2:    return 8;
            2'd3:    return 16;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    // Expected line stream: payload with an inverted copy of each group's last bit.
    task automatic build_exp(input int len, input logic [1:0] m);
        int g = glen(m);
        int k = 0;
        exp_len = 0;
        for (int i = 0; i < len; i++) begin
            exp_bit[exp_len] = payload[i];
            exp_stf[exp_len] = 1'b0;
            exp_len++;
            k++;
            if (g != 0 && k == g) begin
                exp_bit[exp_len] = ~payload[i];
                exp_stf[exp_len] = 1'b1;
                exp_len++;
                k = 0;
            end
        end
    endtask

    task automatic run_loop(input logic [1:0] m, input int len);
        int pi = 0, ei = 0, ri = 0, guard = 0;
        for (int i = 0; i < len; i++) payload[i] = 1'($urandom % 2);
        build_exp(len, m);
        mode = m; loop = 1'b1;
        tx_in_valid = 1'b0; tx_out_ready = 1'b0;
        tx_start = 1'b1; rx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0; rx_start = 1'b0;
        while ((ei < exp_len || ri < len) && guard < 4000) begin
            tx_in_valid  = (pi < len) && ($urandom % 4 != 0);
            tx_in_bit    = payload[pi < len ? pi : 0];
            tx_out_ready = ($urandom % 4 != 0);
            #2;
            if (tx_out_valid && tx_out_ready) begin
                if (ei < exp_len) begin
                    chk(tx_out_bit == exp_bit[ei], exp_stf[ei] ? "R3 inserted bit" : "R2 line bit",
                        int'(tx_out_bit), int'(exp_bit[ei]));
                    if (exp_stf[ei]) chk(tx_in_ready == 1'b0, "R4 upstream held", int'(tx_in_ready), 0);
                    if (m == 2'd0) chk(tx_in_ready == tx_out_ready, "R1 bypass ready",
                                       int'(tx_in_ready), int'(tx_out_ready));
                end else begin
                    chk(1'b0, "R2 extra line bit", ei, exp_len);
                end
                ei++;
            end
            if (tx_in_valid && tx_in_ready) pi++;
            if (rx_out_valid) begin
                if (ri < len) chk(rx_out_bit == payload[ri], "R9 recovered bit", int'(rx_out_bit), int'(payload[ri]));
                else          chk(1'b0, "R9 extra recovered bit", ri, len);
                ri++;
            end
            chk(rx_stuff_err == 1'b0, "R7 no error on clean stream", int'(rx_stuff_err), 0);
            @(negedge clk);
            guard++;
        end
        chk(ei == exp_len, "R2 line bit count", ei, exp_len);
        chk(ri == len, "R9 recovered count", ri, len);
        tx_in_valid = 1'b0; tx_out_ready = 1'b0; loop = 1'b0;
    endtask

    task automatic tx_step(input bit v, input bit b, input bit rdy, input bit st,
                           input bit e_valid, input bit e_bit, input bit e_ready, input string req);
        tx_in_valid = v; tx_in_bit = b; tx_out_ready = rdy; tx_start = st;
        #2;
        chk(tx_out_valid == e_valid, req, int'(tx_out_valid), int'(e_valid));
        if (e_valid) chk(tx_out_bit == e_bit, req, int'(tx_out_bit), int'(e_bit));
        chk(tx_in_ready == e_ready, req, int'(tx_in_ready), int'(e_ready));
        @(negedge clk);
        tx_in_valid = 1'b0; tx_start = 1'b0; tx_out_ready = 1'b0;
    endtask

    task automatic rx_step(input bit b, input bit st, input bit e_valid, input bit e_err, input string req);
        d_rx_valid = 1'b1; d_rx_bit = b; rx_start = st;
        #2;
        chk(rx_out_valid == e_valid, req, int'(rx_out_valid), int'(e_valid));
        chk(rx_stuff_err == e_err, req, int'(rx_stuff_err), int'(e_err));
        @(negedge clk);
        d_rx_valid = 1'b0; rx_start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R9: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mode = 2'd1;
        // Reset state: nothing pending on either path.
        tx_out_ready = 1'b1;
        #2;
        chk(tx_out_valid == 1'b0, "R2 reset no line bit", int'(tx_out_valid), 0);
        chk(tx_in_ready == 1'b1, "R4 reset ready", int'(tx_in_ready), 1);
        chk(rx_out_valid == 1'b0 && rx_stuff_err == 1'b0, "R6 reset rx idle", int'(rx_out_valid), 0);
        @(negedge clk);
        tx_out_ready = 1'b0;

        // R5: group of 4, then a start discards the pending inserted bit.
        tx_step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 start idle");
        tx_step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R2 bit1");
        tx_step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R2 bit2");
        tx_step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R2 bit3");
        tx_step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R2 bit4");
        tx_step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R4 inserted bit stalled");
        tx_step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R5 start drops pending");
        tx_step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R5 new bit2");
        tx_step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R5 new bit3");
        tx_step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R5 new bit4");
        tx_step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R3 inverse of ones");
        tx_step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R4 ready back after one slot");

        // R7 / R6: receive drop with and without polarity error.
        rx_start = 1'b1; @(negedge clk); rx_start = 1'b0;
        rx_step(1'b1, 1'b0, 1'b1, 1'b0, "R6 rx bit1");
        rx_step(1'b0, 1'b0, 1'b1, 1'b0, "R6 rx bit2");
        rx_step(1'b1, 1'b0, 1'b1, 1'b0, "R6 rx bit3");
        rx_step(1'b1, 1'b0, 1'b1, 1'b0, "R6 rx bit4");
        rx_step(1'b1, 1'b0, 1'b0, 1'b1, "R7 bad dropped bit");
        rx_step(1'b0, 1'b0, 1'b1, 1'b0, "R6 next group");
        rx_step(1'b0, 1'b0, 1'b1, 1'b0, "R6 next group");
        rx_step(1'b0, 1'b0, 1'b1, 1'b0, "R6 next group");
        rx_step(1'b0, 1'b0, 1'b1, 1'b0, "R6 next group");
        rx_step(1'b1, 1'b0, 1'b0, 1'b0, "R7 good dropped bit");
        rx_step(1'b0, 1'b0, 1'b1, 1'b0, "R6 after drop");
        // R8: restart mid-group.
        rx_step(1'b1, 1'b1, 1'b1, 1'b0, "R8 start bit1");
        rx_step(1'b0, 1'b0, 1'b1, 1'b0, "R8 bit2");
        rx_step(1'b1, 1'b0, 1'b1, 1'b0, "R8 bit3");
        rx_step(1'b1, 1'b0, 1'b1, 1'b0, "R8 bit4");
        rx_step(1'b0, 1'b0, 1'b0, 1'b0, "R8 drop at new boundary");
        // R6: mode 0 passes every bit.
        mode = 2'd0;
        for (int i = 0; i < 20; i++) rx_step(1'($urandom % 2), 1'b0, 1'b1, 1'b0, "R6 mode0 pass");

        // R1/R2/R3/R4/R9: random loopback runs, plus exact multiples of the group.
        for (int r = 0; r < 6; r++) begin
            for (int m = 0; m < 4; m++) begin
                run_loop(2'(m), 1 + int'($urandom % 200));
            end
        end
        run_loop(2'd1, 8);
        run_loop(2'd2, 16);
        run_loop(2'd3, 48);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule